// File: doc/BRIEF.md
# Transfer Descriptor Retirement Unit

This block sits behind a USB host transfer engine. It takes one general transfer descriptor at a time, after the engine has attempted a transaction on it. It then decides whether the descriptor is finished. A clean completion finishes it. A failure finishes it once the per-descriptor error count reaches its limit. Any other failure sends it back for another attempt. For every request the block produces a write-back set, registered one clock after the request: the updated descriptor control word, the word to store in the descriptor's next-descriptor slot, and the new endpoint queue head pointer.

Finished descriptors are chained onto an internal done list, newest first. Each finished descriptor carries a three-bit interrupt delay, counted in frames. The block keeps a single countdown equal to the smallest delay still pending and lowers it on every start-of-frame pulse. When the countdown reaches zero, the whole list is published in a host-readable done-head register and a one-cycle interrupt pulse is raised. The internal list then starts over empty.

The reset input asserts asynchronously and is released through a synchronizer, so the block leaves reset a fixed number of clocks after `rst_n` rises.

Top module: `tdr_retire_unit`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one cycle of `wb_valid` one clock later, and `wb_valid` is never high otherwise.
- R2: With completion code 0 the descriptor is retired (`wb_retired`=1). In the control word, bits 31:28 become 0, bits 27:26 (error count) become 0 and bit 24 takes `req_toggle`; all other bits are kept. The endpoint head becomes `req_td_next` with bits 3:0 replaced by {0,0,toggle,0}.
- R3: With a nonzero completion code and an incremented error count below 3, the descriptor is not retired. Bits 31:28 take the code, bits 27:26 take the incremented count and bit 24 takes the toggle. `wb_ep_head` equals `req_ep_head`, `wb_td_link` equals `req_td_next`, and the done list and the delay are left as they were.
- R4: With a nonzero code and an incremented count reaching 3 (a count of 3 saturates), the descriptor is retired with the code in bits 31:28 and 3 in bits 27:26. The endpoint head is `req_td_next` with bit 0 (halted) set to 1, bit 1 set to the toggle and bits 3:2 cleared.
- R5: A retired descriptor's `wb_td_link` is the current done-list head (0 when the list is empty), and the descriptor then becomes the head, giving last-in first-out order.
- R6: Bits 23:21 of the incoming control word give a retired descriptor's delay. The value 7 adds no interrupt request. Any other value sets the pending delay to that value, or to the smaller of that value and the remaining count if a delay is already pending.
- R7: Each `sof` pulse lowers a nonzero pending count by one. On the clock after the pending count is at zero, the done-head register takes the list head, the list becomes empty and `irq` is high for one cycle.
- R8: A retirement in the same clock as an expiry starts a new list: its link word is 0, it becomes the only entry, and the pending state comes from its own delay alone.
- R9: `reg_rdata` returns the done-head register when `reg_addr` is 0x30 and 0 for any other address.
- R10: During reset `wb_valid` and `irq` are 0 and the done-head register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Descriptor result present this cycle |
| req_ctrl | input | 32 | Descriptor control word as fetched |
| req_td_addr | input | 32 | Descriptor address (16-byte aligned) |
| req_td_next | input | 32 | Descriptor's next-descriptor word |
| req_ep_head | input | 32 | Current endpoint queue head pointer |
| req_cc | input | 4 | Completion code of the attempt, 0 = success |
| req_toggle | input | 1 | Data toggle after the attempt |
| sof | input | 1 | Start-of-frame pulse |
| reg_addr | input | 8 | Register read offset |
| reg_rdata | output | 32 | Register read data |
| wb_valid | output | 1 | Write-back set valid |
| wb_retired | output | 1 | Descriptor left its endpoint queue |
| wb_ctrl | output | 32 | Updated control word |
| wb_td_link | output | 32 | Word for the descriptor's next-descriptor slot |
| wb_ep_head | output | 32 | New endpoint queue head pointer |
| irq | output | 1 | Done-list interrupt pulse |

## Verification
The bench builds the block with its defaults: an error limit of 3, a two-stage reset synchronizer and the done-head register at 0x30. The limit of 3 fills the two-bit error count, so both the retry path and the saturating retirement can be reached with short descriptor sequences. The three-bit delay field reaches every countdown value and the suppress code, so the bench covers minimum tracking, back-to-back expiries and a retirement landing on an expiry. A long random phase mixes frame pulses with retirements and checks every cycle against a reference model.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

  localparam int WORD_W = 32;

  // descriptor control word field positions (decoded by the transfer engine)
  localparam int CC_LSB  = 28;
  localparam int CC_W    = 4;
  localparam int EC_LSB  = 26;
  localparam int EC_W    = 2;
  localparam int TOG_BIT = 24;
  localparam int DLY_LSB = 21;
  localparam int DLY_W   = 3;

  // endpoint head pointer low bits
  localparam int PTR_LSB   = 4;
  localparam int HALT_BIT  = 0;
  localparam int CARRY_BIT = 1;

  typedef struct packed {
    logic              retire;
    logic              fail;
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] ep_head;
    logic [DLY_W-1:0]  delay;
  } tdr_verdict_t;

endpackage

// File: rtl/tdr_rst_sync.sv
module tdr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/tdr_status_update.sv
module tdr_status_update
  import tdr_pkg::*;
#(
  parameter int ERR_LIMIT = 3
) (
  input  logic [WORD_W-1:0] ctrl_in,
  input  logic [CC_W-1:0]   cc_in,
  input  logic              tog_in,
  input  logic [WORD_W-1:0] ep_head_in,
  input  logic [WORD_W-1:0] td_next_in,
  output tdr_verdict_t      verdict
);

  localparam logic [EC_W-1:0] EC_MAX = EC_W'(ERR_LIMIT);

  logic [EC_W-1:0] ec_old;
  logic [EC_W-1:0] ec_new;
  logic            fail;
  logic            retire;
  logic [WORD_W-1:0] ctrl_upd;
  logic [WORD_W-1:0] head_upd;

  // R2 R3 R4: error count handling
  always_comb begin
    ec_old = ctrl_in[EC_LSB +: EC_W];
    fail   = (cc_in != '0);
    if (!fail) begin
      ec_new = '0;
    end else if (ec_old >= EC_MAX) begin
      ec_new = EC_MAX;
    end else begin
      ec_new = ec_old + 1'b1;
    end
    retire = !fail || (ec_new == EC_MAX);
  end

  always_comb begin
    ctrl_upd                    = ctrl_in;
    ctrl_upd[CC_LSB +: CC_W]    = cc_in;
    ctrl_upd[EC_LSB +: EC_W]    = ec_new;
    ctrl_upd[TOG_BIT]           = tog_in;
  end

  // R2 R4: unlink and fold halt/toggle carry into the low pointer bits
  always_comb begin
    if (retire) begin
      head_upd                  = td_next_in;
      head_upd[PTR_LSB-1:0]     = '0;
      head_upd[CARRY_BIT]       = tog_in;
      head_upd[HALT_BIT]        = fail;
    end else begin
      head_upd                  = ep_head_in;
    end
  end

  always_comb begin
    verdict.retire  = retire;
    verdict.fail    = fail;
    verdict.ctrl    = ctrl_upd;
    verdict.ep_head = head_upd;
    verdict.delay   = ctrl_in[DLY_LSB +: DLY_W];
  end

endmodule

// File: rtl/tdr_done_linker.sv
module tdr_done_linker
  import tdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [WORD_W-1:0] push_addr,
  input  logic              flush_en,
  output logic [WORD_W-1:0] link_word,
  output logic [WORD_W-1:0] done_reg
);

  logic [WORD_W-1:0] head_q;
  logic [WORD_W-1:0] head_d;
  logic [WORD_W-1:0] done_q;
  logic [WORD_W-1:0] done_d;
  logic              upd_en;

  // R5 R8: a push during a flush begins a fresh list
  always_comb begin
    link_word = flush_en ? '0 : head_q;
  end

  // R5 R7: next state of list head and published head
  always_comb begin
    head_d = head_q;
    done_d = done_q;
    if (flush_en) begin
      done_d = head_q;
      head_d = push_en ? push_addr : '0;
    end else if (push_en) begin
      head_d = push_addr;
    end
    upd_en = flush_en || push_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      done_q <= '0;
    end else if (upd_en) begin
      head_q <= head_d;
      done_q <= done_d;
    end
  end

  assign done_reg = done_q;

endmodule

// File: rtl/tdr_irq_delay.sv
module tdr_irq_delay #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_en,
  input  logic [DLY_W-1:0] arm_code,
  input  logic             sof,
  output logic             expire,
  output logic             irq
);

  localparam logic [DLY_W-1:0] NO_IRQ = '1;

  logic             pend_q;
  logic             pend_d;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_d;
  logic [DLY_W-1:0] cnt_dec;
  logic             arm_req;
  logic             irq_q;
  logic             irq_d;
  logic             cnt_en;

  always_comb begin
    arm_req = arm_en && (arm_code != NO_IRQ);  // R6
    expire  = pend_q && (cnt_q == '0);         // R7
  end

  // R6 R7 R8: countdown holding the smallest pending delay
  always_comb begin
    cnt_dec = (pend_q && sof) ? (cnt_q - 1'b1) : cnt_q;
    pend_d  = pend_q;
    cnt_d   = cnt_dec;
    if (expire) begin
      pend_d = arm_req;
      cnt_d  = arm_code;
    end else if (arm_req) begin
      pend_d = 1'b1;
      if (pend_q && (cnt_dec < arm_code)) begin
        cnt_d = cnt_dec;
      end else begin
        cnt_d = arm_code;
      end
    end
    cnt_en = expire || arm_req || (pend_q && sof);
    irq_d  = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/tdr_retire_unit.sv
module tdr_retire_unit
  import tdr_pkg::*;
#(
  parameter int                ERR_LIMIT     = 3,
  parameter int                SYNC_STAGES   = 2,
  parameter int                REG_AW        = 8,
  parameter logic [REG_AW-1:0] DONE_HEAD_OFS = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_ctrl,
  input  logic [31:0]       req_td_addr,
  input  logic [31:0]       req_td_next,
  input  logic [31:0]       req_ep_head,
  input  logic [3:0]        req_cc,
  input  logic              req_toggle,
  input  logic              sof,
  input  logic [REG_AW-1:0] reg_addr,
  output logic [31:0]       reg_rdata,
  output logic              wb_valid,
  output logic              wb_retired,
  output logic [31:0]       wb_ctrl,
  output logic [31:0]       wb_td_link,
  output logic [31:0]       wb_ep_head,
  output logic              irq
);

  logic              rst_sync_n;
  tdr_verdict_t      verdict;
  logic              retire_now;
  logic              expire;
  logic [WORD_W-1:0] link_word;
  logic [WORD_W-1:0] done_reg;

  logic              wb_valid_q;
  logic              wb_valid_d;
  logic              wb_retired_q;
  logic              wb_retired_d;
  logic [WORD_W-1:0] wb_ctrl_q;
  logic [WORD_W-1:0] wb_ctrl_d;
  logic [WORD_W-1:0] wb_link_q;
  logic [WORD_W-1:0] wb_link_d;
  logic [WORD_W-1:0] wb_head_q;
  logic [WORD_W-1:0] wb_head_d;

  tdr_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tdr_status_update #(
    .ERR_LIMIT (ERR_LIMIT)
  ) u_status (
    .ctrl_in    (req_ctrl),
    .cc_in      (req_cc),
    .tog_in     (req_toggle),
    .ep_head_in (req_ep_head),
    .td_next_in (req_td_next),
    .verdict    (verdict)
  );

  assign retire_now = req_valid && verdict.retire;

  tdr_done_linker u_linker (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_en   (retire_now),
    .push_addr (req_td_addr),
    .flush_en  (expire),
    .link_word (link_word),
    .done_reg  (done_reg)
  );

  tdr_irq_delay #(
    .DLY_W (DLY_W)
  ) u_delay (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .arm_en   (retire_now),
    .arm_code (verdict.delay),
    .sof      (sof),
    .expire   (expire),
    .irq      (irq)
  );

  // R1 R3 R5: write-back set, next state
  always_comb begin
    wb_valid_d   = req_valid;
    wb_retired_d = verdict.retire;
    wb_ctrl_d    = verdict.ctrl;
    wb_head_d    = verdict.ep_head;
    wb_link_d    = verdict.retire ? link_word : req_td_next;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wb_valid_q <= 1'b0;
    end else begin
      wb_valid_q <= wb_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wb_retired_q <= 1'b0;
      wb_ctrl_q    <= '0;
      wb_link_q    <= '0;
      wb_head_q    <= '0;
    end else if (req_valid) begin
      wb_retired_q <= wb_retired_d;
      wb_ctrl_q    <= wb_ctrl_d;
      wb_link_q    <= wb_link_d;
      wb_head_q    <= wb_head_d;
    end
  end

  assign wb_valid   = wb_valid_q;
  assign wb_retired = wb_retired_q;
  assign wb_ctrl    = wb_ctrl_q;
  assign wb_td_link = wb_link_q;
  assign wb_ep_head = wb_head_q;

  // R9: host-visible done-head register
  always_comb begin
    reg_rdata = (reg_addr == DONE_HEAD_OFS) ? done_reg : '0;
  end

endmodule

// File: rtl/tdr_retire_checker.sv
module tdr_retire_checker
  import tdr_pkg::*;
#(
  parameter int ERR_LIMIT = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        wb_valid,
  input logic        wb_retired,
  input logic [31:0] wb_ctrl,
  input logic [31:0] wb_ep_head
);

  localparam logic [EC_W-1:0] EC_MAX = EC_W'(ERR_LIMIT);

  AST_WB_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> wb_valid);  // R1

  AST_WB_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !wb_valid);  // R1

  AST_SUCCESS_RETIRES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ctrl[CC_LSB +: CC_W] == '0) |-> (wb_retired && wb_ctrl[EC_LSB +: EC_W] == '0));  // R2

  AST_RETIRE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_retired) |-> (wb_ep_head[CARRY_BIT] == wb_ctrl[TOG_BIT]));  // R2

  AST_RETRY_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_retired) |-> (wb_ctrl[CC_LSB +: CC_W] != '0 && wb_ctrl[EC_LSB +: EC_W] != EC_MAX));  // R3

  AST_HALT_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_retired) |-> (wb_ep_head[HALT_BIT] == (wb_ctrl[CC_LSB +: CC_W] != '0)));  // R4

endmodule

bind tdr_retire_unit tdr_retire_checker #(
  .ERR_LIMIT (ERR_LIMIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .wb_valid   (wb_valid),
  .wb_retired (wb_retired),
  .wb_ctrl    (wb_ctrl),
  .wb_ep_head (wb_ep_head)
);

// File: tb/tb_tdr_retire_unit.sv
module tb_tdr_retire_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_ctrl;
  logic [31:0] req_td_addr;
  logic [31:0] req_td_next;
  logic [31:0] req_ep_head;
  logic [3:0]  req_cc;
  logic        req_toggle;
  logic        sof;
  logic [7:0]  reg_addr;
  logic [31:0] reg_rdata;
  logic        wb_valid;
  logic        wb_retired;
  logic [31:0] wb_ctrl;
  logic [31:0] wb_td_link;
  logic [31:0] wb_ep_head;
  logic        irq;

  tdr_retire_unit dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ctrl    (req_ctrl),
    .req_td_addr (req_td_addr),
    .req_td_next (req_td_next),
    .req_ep_head (req_ep_head),
    .req_cc      (req_cc),
    .req_toggle  (req_toggle),
    .sof         (sof),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .wb_valid    (wb_valid),
    .wb_retired  (wb_retired),
    .wb_ctrl     (wb_ctrl),
    .wb_td_link  (wb_td_link),
    .wb_ep_head  (wb_ep_head),
    .irq         (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int irq_seen = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] cc, input logic [1:0] ec,
                                     input logic tog, input logic [2:0] di);
    return {cc, ec, 1'b0, tog, di, 21'h0_5A3C};
  endfunction

  // expectation generator: reference model built from the requirements
  typedef struct {
    logic        retired;
    logic [31:0] ctrl;
    logic [31:0] link;
    logic [31:0] ep;
    string       tag;
    string       ltag;
  } exp_t;
  exp_t exp_q[$];

  logic [31:0] m_head;
  logic [31:0] m_done;
  logic        m_pend;
  logic [2:0]  m_cnt;
  logic        m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_head <= '0; m_done <= '0; m_pend <= 1'b0; m_cnt <= '0; m_irq <= 1'b0;
    end else begin
      logic       ex, fl, ret, rn, arm;
      logic [1:0] ec, ecn;
      logic [2:0] di, dec;
      exp_t       e;
      ex  = m_pend && (m_cnt == 3'd0);
      ret = 1'b0;
      fl  = 1'b0;
      if (req_valid) begin
        ec  = req_ctrl[27:26];
        fl  = (req_cc != 4'd0);
        ecn = !fl ? 2'd0 : ((ec == 2'd3) ? 2'd3 : ec + 2'd1);
        ret = !fl || (ecn == 2'd3);
        e.retired = ret;
        e.ctrl = req_ctrl;
        e.ctrl[31:28] = req_cc;
        e.ctrl[27:26] = ecn;
        e.ctrl[24] = req_toggle;
        e.link = ret ? (ex ? 32'd0 : m_head) : req_td_next;
        e.ep   = ret ? {req_td_next[31:4], 2'b00, req_toggle, fl} : req_ep_head;
        e.tag  = !ret ? "R3" : (fl ? "R4" : "R2");
        e.ltag = (ret && ex) ? "R8" : (ret ? "R5" : "R3");
        exp_q.push_back(e);
      end
      rn  = req_valid && ret;
      di  = req_ctrl[23:21];
      arm = rn && (di != 3'd7);
      dec = (m_pend && sof) ? m_cnt - 3'd1 : m_cnt;
      if (ex) begin
        m_done <= m_head;
        m_head <= rn ? req_td_addr : 32'd0;
        m_irq  <= 1'b1;
        m_pend <= arm;
        m_cnt  <= di;
      end else begin
        m_irq <= 1'b0;
        if (rn) m_head <= req_td_addr;
        if (arm) begin
          m_pend <= 1'b1;
          m_cnt  <= (m_pend && dec < di) ? dec : di;
        end else begin
          m_cnt <= dec;
        end
      end
    end
  end

  // monitor: pops expected items and compares, away from the clock edge
  always begin
    @(negedge clk);
    #1;
    if (mon_on) begin
      if (wb_valid) begin
        if (exp_q.size() == 0) begin
          chk("R1 unexpected wb_valid", {31'd0, wb_valid}, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({e.tag, " retired"}, {31'd0, wb_retired}, {31'd0, e.retired});
          chk({e.tag, " ctrl"}, wb_ctrl, e.ctrl);
          chk({e.tag, " ep_head"}, wb_ep_head, e.ep);
          chk({e.ltag, " link"}, wb_td_link, e.link);
        end
      end else if (exp_q.size() != 0) begin
        void'(exp_q.pop_front());
        chk("R1 missing wb_valid", {31'd0, wb_valid}, 32'd1);
      end
      chk("R7 irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R9 reg_rdata", reg_rdata, (reg_addr == 8'h30) ? m_done : 32'd0);
      if (irq) irq_seen++;
    end
  end

  // driver
  task automatic send(input logic [31:0] addr, input logic [31:0] nxt, input logic [31:0] eph,
                      input logic [31:0] ctrl, input logic [3:0] cc, input logic tog, input logic s);
    req_valid = 1'b1; req_td_addr = addr; req_td_next = nxt; req_ep_head = eph;
    req_ctrl = ctrl; req_cc = cc; req_toggle = tog; sof = s;
    @(negedge clk);
    req_valid = 1'b0; sof = 1'b0;
  endtask

  task automatic frame();
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int base;
    rst_n = 1'b0; req_valid = 1'b0; req_ctrl = '0; req_td_addr = '0; req_td_next = '0;
    req_ep_head = '0; req_cc = '0; req_toggle = 1'b0; sof = 1'b0; reg_addr = 8'h30;
    idle(4);
    #1;
    // R10: reset state
    chk("R10 wb_valid", {31'd0, wb_valid}, 32'd0);
    chk("R10 irq", {31'd0, irq}, 32'd0);
    chk("R10 done head", reg_rdata, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    mon_on = 1'b1;

    // R2 R5: clean completion onto an empty list
    send(32'h0000_1000, 32'h0000_1100, 32'h0000_1000, mk(4'hF, 2'd2, 1'b0, 3'd7), 4'd0, 1'b1, 1'b0);
    #1;
    chk("R5 first link", wb_td_link, 32'd0);
    chk("R2 ep_head", wb_ep_head, 32'h0000_1102);
    chk("R2 ctrl", wb_ctrl, mk(4'h0, 2'd0, 1'b1, 3'd7));
    // R5: LIFO order
    send(32'h0000_2000, 32'h0000_2100, 32'h0000_2000, mk(4'h0, 2'd0, 1'b1, 3'd7), 4'd0, 1'b0, 1'b0);
    #1;
    chk("R5 second link", wb_td_link, 32'h0000_1000);
    // R3: retry below the limit
    send(32'h0000_3000, 32'h0000_3100, 32'h0000_3002, mk(4'h0, 2'd0, 1'b1, 3'd1), 4'd5, 1'b1, 1'b0);
    #1;
    chk("R3 not retired", {31'd0, wb_retired}, 32'd0);
    chk("R3 ep_head kept", wb_ep_head, 32'h0000_3002);
    chk("R3 ctrl", wb_ctrl, mk(4'h5, 2'd1, 1'b1, 3'd1));
    // R4: third failure retires and halts
    send(32'h0000_3000, 32'h0000_3100, 32'h0000_3002, mk(4'h0, 2'd2, 1'b1, 3'd7), 4'd5, 1'b0, 1'b0);
    #1;
    chk("R4 retired", {31'd0, wb_retired}, 32'd1);
    chk("R4 ep_head halted", wb_ep_head, 32'h0000_3101);
    chk("R4 ctrl", wb_ctrl, mk(4'h5, 2'd3, 1'b0, 3'd7));
    chk("R4 link", wb_td_link, 32'h0000_2000);

    // R6: code 7 never interrupts
    repeat (6) frame();
    idle(2);
    chk("R6 no irq for code 7", irq_seen, 0);

    // R6 R7: minimum of pending delays, then expiry
    send(32'h0000_4000, 32'h0, 32'h0, mk(4'h0, 2'd0, 1'b0, 3'd3), 4'd0, 1'b0, 1'b0);
    frame();
    send(32'h0000_5000, 32'h0, 32'h0, mk(4'h0, 2'd0, 1'b0, 3'd1), 4'd0, 1'b0, 1'b0);
    frame();
    #1;
    chk("R7 irq not early", {31'd0, irq}, 32'd0);
    @(negedge clk);
    #1;
    chk("R6 irq after min delay", {31'd0, irq}, 32'd1);
    chk("R7 done head", reg_rdata, 32'h0000_5000);
    @(negedge clk);
    // R7: list restarted empty after publication
    send(32'h0000_6000, 32'h0, 32'h0, mk(4'h0, 2'd0, 1'b0, 3'd7), 4'd0, 1'b0, 1'b0);
    #1;
    chk("R7 link after flush", wb_td_link, 32'd0);

    // R8: retirement coinciding with expiry
    send(32'h0000_7000, 32'h0, 32'h0, mk(4'h0, 2'd0, 1'b0, 3'd0), 4'd0, 1'b0, 1'b0);
    send(32'h0000_8000, 32'h0, 32'h0, mk(4'h0, 2'd0, 1'b0, 3'd2), 4'd0, 1'b0, 1'b0);
    #1;
    chk("R8 link on expiry", wb_td_link, 32'd0);
    chk("R8 irq", {31'd0, irq}, 32'd1);
    chk("R8 published head", reg_rdata, 32'h0000_7000);
    frame();
    frame();
    @(negedge clk);
    #1;
    chk("R8 second irq", {31'd0, irq}, 32'd1);
    chk("R8 new list head", reg_rdata, 32'h0000_8000);

    // R9: other offsets read zero
    @(negedge clk);
    reg_addr = 8'h2C;
    #2;
    chk("R9 other offset", reg_rdata, 32'd0);
    @(negedge clk);
    reg_addr = 8'h30;

    // random mix, compared cycle by cycle (R1..R9)
    for (int i = 0; i < 3000; i++) begin
      base = $urandom();
      req_valid   = ($urandom_range(0, 1) == 1);
      req_td_addr = $urandom() & 32'hFFFF_FFF0;
      req_td_next = $urandom() & 32'hFFFF_FFF0;
      req_ep_head = $urandom();
      req_ctrl    = base;
      req_cc      = ($urandom_range(0, 1) == 1) ? 4'd0 : 4'($urandom_range(1, 15));
      req_toggle  = 1'($urandom_range(0, 1));
      sof         = ($urandom_range(0, 3) == 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    sof = 1'b0;
    repeat (10) frame();
    idle(3);
    chk("R1 queue drained", exp_q.size(), 0);
    finish_run();
  end

endmodule